// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block executes the configuration step of a vector unit. Each request carries an application vector length taken from a scalar source register, a proposed vector-type word, and the indices of the source and destination scalar registers. The unit checks the type word for legality, derives the largest element count the configuration allows from the parameterised vector register width, element width and register grouping factor, and then updates its own length and type registers.

The new length comes back one cycle later, with a single-cycle response pulse, as the value to write to the destination register. The same pulse marks the vector state as modified. Two register-index combinations select special cases. A zero source index with a nonzero destination index asks for the largest legal length. Zero for both indices keeps the current length, subject to the limit of the new configuration. Decode, register file access, flushing and the element datapath belong to other blocks.

Top module: `vcfg_unit`

## Requirements
- R1: While reset is held and right after it is released, the length register reads 0, the type register holds only its top bit (illegal flag) set, and the response, dirty and write-back outputs are low.
- R2: A request accepted on a clock edge produces rsp_valid_o and vs_dirty_o high for exactly the next cycle, whether the configuration is legal or illegal. Without a request, the length and type registers keep their values.
- R3: The type word has these fields: bits [2:0] are the grouping code, bits [5:3] are the width code, bits 6 and 7 are two policy flags, bits [9:8] are the divider field, bits [XLEN-2:10] are reserved, and bit XLEN-1 is the illegal flag. The element width is 8 shifted left by the width code.
- R4: For a grouping code from 0 to 3 the limit is (VLEN / width) shifted left by the code.
- R5: For a grouping code from 5 to 7 the grouping is fractional and the limit is (VLEN / width) shifted right by (8 - code). Such a configuration is illegal when ELEN shifted right by (8 - code) is smaller than the width.
- R6: Grouping code 4 is illegal.
- R7: A configuration is also illegal when the width exceeds ELEN, the incoming illegal flag is set, the divider field is nonzero, or any reserved bit is nonzero.
- R8: On an illegal configuration the type register becomes the illegal flag alone, with all other bits zero, and the length becomes 0.
- R9: On a legal configuration with a nonzero source index, the length becomes the smaller of the requested length and the limit. The type register stores the word as given, with the illegal flag clear.
- R10: With source index 0 and a nonzero destination index, a legal configuration sets the length to the limit.
- R11: With source and destination index both 0, the requested length is the current length, so a legal configuration sets the length to the smaller of the current length and the new limit.
- R12: wb_en_o is high together with the response exactly when the destination index is nonzero. wb_idx_o then carries that index and wb_data_o the new length, zero-extended. The registers update even when no write-back occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Configuration request strobe |
| avl_i | input | XLEN | Requested length from the source register |
| vtype_i | input | XLEN | Proposed type word |
| rs1_idx_i | input | 5 | Source register index |
| rd_idx_i | input | 5 | Destination register index |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| vs_dirty_o | output | 1 | Vector state modified, pulsed with the response |
| wb_en_o | output | 1 | Destination write-back enable |
| wb_idx_o | output | 5 | Destination register index |
| wb_data_o | output | XLEN | New length, zero-extended |
| vl_o | output | clog2(VLEN+1) | Current length register |
| vtype_o | output | XLEN | Current type register |

## Verification
The hardest case to reach is the keep-length request with both indices zero in which the new configuration has a smaller limit than the length already held. It only shows up when a long length was set first and a narrower or fractional configuration then follows. The stimulus therefore first sets the maximum length with an eight-register grouping. It then issues keep-length requests with a wider element and a fractional grouping, and finally an illegal one. The random phase draws zero indices often, so chains of keep-length requests follow each other back to back.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
    localparam int LMUL_LSB = 0;
    localparam int SEW_LSB  = 3;
    localparam int EDIV_LSB = 8;
    localparam int RSV_LSB  = 10;

    typedef struct packed {
        logic [1:0] ediv;
        logic       pol_mask;
        logic       pol_tail;
        logic [2:0] sew;
        logic [2:0] lmul;
    } vtype_lo_t;
endpackage

// File: rtl/vcfg_legal.sv
module vcfg_legal #(
    parameter int ELEN = 64
) (
    input  logic [2:0] lmul_i,
    input  logic [2:0] sew_i,
    input  logic [1:0] ediv_i,
    input  logic       vill_i,
    input  logic       rsv_any_i,
    output logic       legal_o
);
    logic [11:0] width;
    logic [31:0] elen_frac;
    logic        width_bad;
    logic        frac_bad;

    always_comb begin
        width     = 12'd8 << sew_i;
        width_bad = 32'(width) > 32'(ELEN);
        elen_frac = 32'(ELEN) >> (4'd8 - {1'b0, lmul_i});
        frac_bad  = lmul_i[2] && ((lmul_i == 3'b100) || (elen_frac < 32'(width)));
        legal_o   = !(vill_i || rsv_any_i || width_bad || frac_bad || (ediv_i != 2'b00));
    end
endmodule

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax #(
    parameter int VLEN = 128,
    parameter int VL_W = 8
) (
    input  logic [2:0]      lmul_i,
    input  logic [2:0]      sew_i,
    output logic [VL_W-1:0] vlmax_o
);
    logic [VL_W-1:0] per_reg;

    always_comb begin
        per_reg = VL_W'(VLEN) >> ({1'b0, sew_i} + 4'd3);
        if (lmul_i[2]) begin
            vlmax_o = per_reg >> (4'd8 - {1'b0, lmul_i});
        end else begin
            vlmax_o = per_reg << lmul_i;
        end
    end
endmodule

// File: rtl/vcfg_avl_sel.sv
module vcfg_avl_sel #(
    parameter int XLEN = 32,
    parameter int VL_W = 8
) (
    input  logic [XLEN-1:0] avl_i,
    input  logic            keep_i,
    input  logic            use_max_i,
    input  logic [VL_W-1:0] cur_vl_i,
    input  logic [VL_W-1:0] vlmax_i,
    output logic [VL_W-1:0] vl_o
);
    logic [XLEN-1:0] eff;

    always_comb begin
        if (keep_i) begin
            eff = XLEN'(cur_vl_i);
        end else if (use_max_i) begin
            eff = '1;
        end else begin
            eff = avl_i;
        end
        vl_o = (eff < XLEN'(vlmax_i)) ? eff[VL_W-1:0] : vlmax_i;
    end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
    import vcfg_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int VLEN  = 128,
    parameter int ELEN  = 64,
    parameter int IDX_W = 5,
    localparam int VL_W = $clog2(VLEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [XLEN-1:0]  avl_i,
    input  logic [XLEN-1:0]  vtype_i,
    input  logic [IDX_W-1:0] rs1_idx_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             rsp_valid_o,
    output logic             vs_dirty_o,
    output logic             wb_en_o,
    output logic [IDX_W-1:0] wb_idx_o,
    output logic [XLEN-1:0]  wb_data_o,
    output logic [VL_W-1:0]  vl_o,
    output logic [XLEN-1:0]  vtype_o
);
    localparam logic [XLEN-1:0] ILL_ONLY = {1'b1, {(XLEN-1){1'b0}}};

    typedef struct packed {
        logic             rsp;
        logic             wb;
        logic [IDX_W-1:0] idx;
        logic [VL_W-1:0]  vl;
        logic [XLEN-1:0]  vtype;
    } state_t;

    state_t    st_d, st_q;
    vtype_lo_t fld;
    logic      legal;
    logic      rs1_zero, rd_zero;
    logic [VL_W-1:0] vlmax, vl_new;

    assign fld      = vtype_lo_t'(vtype_i[RSV_LSB-1:0]);
    assign rs1_zero = (rs1_idx_i == '0);
    assign rd_zero  = (rd_idx_i == '0);

    vcfg_legal #(.ELEN(ELEN)) legal_i (
        .lmul_i    (fld.lmul),
        .sew_i     (fld.sew),
        .ediv_i    (fld.ediv),
        .vill_i    (vtype_i[XLEN-1]),
        .rsv_any_i (|vtype_i[XLEN-2:RSV_LSB]),
        .legal_o   (legal)
    );

    vcfg_vlmax #(.VLEN(VLEN), .VL_W(VL_W)) vlmax_i (
        .lmul_i  (fld.lmul),
        .sew_i   (fld.sew),
        .vlmax_o (vlmax)
    );

    vcfg_avl_sel #(.XLEN(XLEN), .VL_W(VL_W)) avl_sel_i (
        .avl_i     (avl_i),
        .keep_i    (rs1_zero && rd_zero),
        .use_max_i (rs1_zero),
        .cur_vl_i  (st_q.vl),
        .vlmax_i   (vlmax),
        .vl_o      (vl_new)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rsp = req_valid_i;
        st_d.wb  = 1'b0;
        if (req_valid_i) begin
            st_d.wb  = !rd_zero;
            st_d.idx = rd_idx_i;
            if (legal) begin
                st_d.vl    = vl_new;
                st_d.vtype = {1'b0, vtype_i[XLEN-2:0]};
            end else begin
                st_d.vl    = '0;
                st_d.vtype = ILL_ONLY;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rsp: 1'b0, wb: 1'b0, idx: '0, vl: '0, vtype: ILL_ONLY};
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o = st_q.rsp;
    assign vs_dirty_o  = st_q.rsp;
    assign wb_en_o     = st_q.wb;
    assign wb_idx_o    = st_q.idx;
    assign wb_data_o   = XLEN'(st_q.vl);
    assign vl_o        = st_q.vl;
    assign vtype_o     = st_q.vtype;

    assert_rsp_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> (rsp_valid_o && vs_dirty_o));
    assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(req_valid_i));
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> ($stable(vl_o) && $stable(vtype_o)));
    assert_illegal_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vtype_o[XLEN-1] |-> (vl_o == '0 && vtype_o[XLEN-2:0] == '0));
    assert_keep_not_grow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && rs1_idx_i == '0 && rd_idx_i == '0) |=> (vl_o <= $past(vl_o)));
    assert_no_wb_x0_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (rsp_valid_o && wb_idx_o != '0));
    assert_vl_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        32'(vl_o) <= 32'(VLEN));
endmodule

// File: tb/vcfg_unit_tb_top.sv
module vcfg_unit_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int XLEN = 32;
    localparam int VLEN = 128;
    localparam int ELEN = 64;
    localparam int VL_W = $clog2(VLEN + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [XLEN-1:0] avl = '0;
    logic [XLEN-1:0] vtype = '0;
    logic [4:0]      rs1 = '0;
    logic [4:0]      rd = '0;
    logic            rsp_valid, vs_dirty, wb_en;
    logic [4:0]      wb_idx;
    logic [XLEN-1:0] wb_data, vtype_out;
    logic [VL_W-1:0] vl_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_tag = "R1";

    // reference state
    bit          m_rsp = 0, m_wb = 0;
    logic [4:0]  m_idx = '0;
    longint      m_vl = 0;
    logic [31:0] m_vtype = 32'h8000_0000;
    string       m_tag = "R1";

    always #2.5 clk = ~clk;

    vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .avl_i(avl),
        .vtype_i(vtype), .rs1_idx_i(rs1), .rd_idx_i(rd),
        .rsp_valid_o(rsp_valid), .vs_dirty_o(vs_dirty), .wb_en_o(wb_en),
        .wb_idx_o(wb_idx), .wb_data_o(wb_data), .vl_o(vl_out), .vtype_o(vtype_out)
    );

    function automatic logic [31:0] mk(int lmul, int sew, int ta, int ma);
        logic [31:0] w;
        w = '0;
        w[2:0] = 3'(lmul);
        w[5:3] = 3'(sew);
        w[6]   = 1'(ta);
        w[7]   = 1'(ma);
        return w;
    endfunction

    // behavioural model: R3..R12
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_rsp = 0; m_wb = 0; m_vl = 0; m_vtype = 32'h8000_0000; m_tag = "R1";
        end else begin
            m_rsp = req_valid;
            m_wb  = 0;
            m_tag = req_valid ? cur_tag : "R2";
            if (req_valid) begin
                int     lm, sw, width, lim;
                bit     bad;
                longint want;
                lm = int'(vtype[2:0]);
                sw = int'(vtype[5:3]);
                width = 8 << sw;
                bad = vtype[31] || (vtype[9:8] != 0) || (vtype[30:10] != 0) || (width > ELEN) || (lm == 4);
                if (lm > 4 && ((ELEN >> (8 - lm)) < width)) bad = 1;
                m_wb  = (rd != 0);
                m_idx = rd;
                if (bad) begin
                    m_vl = 0;
                    m_vtype = 32'h8000_0000;
                end else begin
                    lim = (lm > 4) ? ((VLEN / width) >> (8 - lm)) : ((VLEN / width) << lm);
                    if (rs1 == 0 && rd == 0) want = m_vl;
                    else if (rs1 == 0) want = 64'h7fff_ffff_ffff;
                    else want = longint'(avl);
                    m_vl = (want < lim) ? want : lim;
                    m_vtype = vtype & 32'h7fff_ffff;
                end
            end
        end
    end

    task automatic chk(string name, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", m_tag, name, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("rsp_valid", longint'(rsp_valid), longint'(m_rsp));
            chk("vs_dirty", longint'(vs_dirty), longint'(m_rsp));
            chk("wb_en", longint'(wb_en), longint'(m_rsp && m_wb));
            chk("vl", longint'(vl_out), m_vl);
            chk("vtype", longint'(vtype_out), longint'(m_vtype));
            if (m_rsp && m_wb) begin
                chk("wb_idx", longint'(wb_idx), longint'(m_idx));
                chk("wb_data", longint'(wb_data), m_vl);
            end
        end
    end

    task automatic issue(string tag, logic [31:0] a, logic [31:0] vt, int s1, int d);
        @(negedge clk);
        cur_tag = tag;
        req_valid = 1'b1;
        avl = a;
        vtype = vt;
        rs1 = 5'(s1);
        rd = 5'(d);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            avl = $urandom;
            vtype = $urandom;
            rs1 = 5'($urandom);
            rd = 5'($urandom);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);   // R1 reset values compared here
        rst_n = 1'b1;
        idle(2);
        // R9 legal clamp to requested length and to limit
        issue("R9", 32'd5, mk(0, 2, 1, 0), 1, 2);
        issue("R9", 32'd3, mk(0, 2, 0, 1), 3, 4);
        idle(1);
        // R3 every width code
        for (int s = 0; s < 8; s++) issue("R3", 32'd1000, mk(1, s, 0, 0), 5, 6);
        // R4 integer grouping
        for (int l = 0; l < 4; l++) issue("R4", 32'd1000, mk(l, 0, 1, 1), 7, 8);
        // R5 fractional grouping, legal and illegal edges
        issue("R5", 32'd1000, mk(7, 0, 0, 0), 9, 10);
        issue("R5", 32'd1000, mk(5, 0, 0, 0), 9, 10);
        issue("R5", 32'd1000, mk(5, 1, 0, 0), 9, 10);
        issue("R5", 32'd1000, mk(6, 3, 0, 0), 9, 10);
        issue("R5", 32'd1000, mk(7, 3, 0, 0), 9, 10);
        // R6 reserved grouping code
        issue("R6", 32'd4, mk(4, 0, 0, 0), 1, 1);
        // R7 other illegal causes, then R8 result
        issue("R9", 32'd9, mk(0, 0, 0, 0), 1, 1);
        issue("R7", 32'd9, mk(0, 4, 0, 0), 1, 1);
        issue("R7", 32'd9, mk(0, 0, 0, 0) | 32'h8000_0000, 1, 1);
        issue("R7", 32'd9, mk(0, 0, 0, 0) | 32'h0000_0100, 1, 1);
        issue("R8", 32'd9, mk(0, 0, 0, 0) | 32'h0000_0400, 1, 1);
        // R10 maximum length request
        issue("R10", 32'd0, mk(3, 0, 0, 0), 0, 7);
        // R11 keep current length, then narrow
        issue("R11", 32'd0, mk(3, 0, 0, 0), 0, 0);
        issue("R11", 32'd0, mk(0, 1, 0, 0), 0, 0);
        issue("R11", 32'd0, mk(7, 2, 0, 0), 0, 0);
        issue("R11", 32'd0, mk(4, 0, 0, 0), 0, 0);
        issue("R11", 32'd0, mk(3, 0, 0, 0), 0, 0);
        // R12 no write-back to index 0 but state still updates
        issue("R12", 32'd6, mk(2, 1, 1, 0), 4, 0);
        idle(2);
        // mixed random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] vt;
            vt = mk($urandom_range(7), $urandom_range(4), $urandom_range(1), $urandom_range(1));
            if ($urandom_range(15) == 0) vt[31] = 1'b1;
            if ($urandom_range(15) == 0) vt[9:8] = 2'($urandom_range(3));
            if ($urandom_range(15) == 0) vt[10 + $urandom_range(20)] = 1'b1;
            issue("R9", ($urandom_range(1) == 1) ? 32'($urandom_range(200)) : $urandom, vt,
                  ($urandom_range(2) == 0) ? 0 : int'($urandom_range(31)),
                  ($urandom_range(2) == 0) ? 0 : int'($urandom_range(31)));
            if ($urandom_range(3) == 0) idle(1);
        end
        idle(3);
        finish_run();
    end
endmodule